// File: doc/BRIEF.md
# Probe-Controlled Loadable Counter

This block is a free-running up-counter placed in a user design. A management controller observes it and steers it only through a bank of logic-analyzer probes. Each probe channel has a data bit that the management side drives, an active-low output enable, and a data bit that the block returns. The counter value is returned on the lowest probe channels. A load value arrives on the next group of channels. The two channels above the load group can supply the counter's clock and reset in place of the system bus clock and bus reset.

No dedicated control register exists. Everything is decided by which probe channels the management side is currently driving. A load channel that is driven forces its counter bit to the probe value on every clock edge, so a fully enabled load group pins the counter to the load value until the enables are released. When the clock channel is driven, its data bit becomes the counter clock, and the management side can single-step the counter by toggling it through successive writes. When the reset channel is driven, its data bit becomes the counter reset.

On each edge of the selected clock the core decodes one of three actions, in priority order. ACT_CLEAR is taken when the selected reset is high. ACT_LOAD is taken when any load channel is driven. ACT_STEP is taken otherwise. The transitions are: ACT_CLEAR whenever reset is asserted; ACT_CLEAR to ACT_LOAD or ACT_STEP when reset is released; ACT_STEP to ACT_LOAD when a load enable goes low; ACT_LOAD to ACT_STEP when every load enable is high again.

Top module: `probe_counter_top`

## Requirements
- R1: probe_obs[CNT_W-1:0] always shows the current count, and every probe_obs bit at or above CNT_W reads 0.
- R2: When the selected reset is high at a rising edge of the selected clock, the count becomes 0. Reset is active high, synchronous, and overrides any load.
- R3: On each rising edge of the selected clock with reset low and no load channel driven, the count increases by one, wrapping from all ones to 0.
- R4: Load channel i is probe index CNT_W+i, and it is driven when probe_oen_n[CNT_W+i] is 0. On an edge where at least one load channel is driven, each driven bit i takes probe_drv[CNT_W+i] and each undriven bit keeps its previous value. No increment happens on that edge.
- R5: While load channels remain driven, the load repeats on every edge, so a fully driven group holds the count at the load value. After every load enable returns to 1, counting resumes from the loaded value.
- R6: The clock channel is probe index 2*CNT_W. When probe_oen_n[2*CNT_W] is 0, the counter is clocked by probe_drv[2*CNT_W] and bus_clk edges have no effect. Otherwise the counter is clocked by bus_clk.
- R7: The reset channel is probe index 2*CNT_W+1. When probe_oen_n[2*CNT_W+1] is 0, the reset is probe_drv[2*CNT_W+1] and bus_rst is ignored. Otherwise the reset is bus_rst.
- R8: After one edge that loads 0, followed by release of the load, the count after N further edges equals N. It therefore exceeds 500 after 501 edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_clk | input | 1 | System bus clock, the default counter clock |
| bus_rst | input | 1 | System bus reset, active high, the default counter reset |
| probe_drv | input | PROBE_W | Probe data driven by the management side |
| probe_oen_n | input | PROBE_W | Active-low probe output enables from the management side |
| probe_obs | output | PROBE_W | Probe data returned to the management side |

## Verification
The count is a single register on the selected clock, and probe_obs follows it combinationally. Every load, reset and increment therefore appears on probe_obs one edge after its inputs are applied. In bus-clock mode the bench drives inputs on falling edges and samples at the next falling edge, so each check sees exactly one rising edge. In probe-clock mode the bench raises the clock channel, waits a short delay, checks, and only then lowers it again. Bus-clock edges are then allowed to pass to show that they do not move the count.

// File: rtl/probe_cnt_pkg.sv
package probe_cnt_pkg;

    // Action decoded on each edge of the selected counter clock.
    typedef enum logic [1:0] {
        ACT_CLEAR = 2'd0,
        ACT_LOAD  = 2'd1,
        ACT_STEP  = 2'd2
    } cnt_act_e;

endpackage

// File: rtl/probe_src_select.sv
module probe_src_select (
    input  logic bus_clk,
    input  logic bus_rst,
    input  logic clk_probe,
    input  logic clk_probe_oen_n,
    input  logic rst_probe,
    input  logic rst_probe_oen_n,
    output logic sel_clk,
    output logic sel_rst
);

    // A channel is taken over by the management side when its enable is low.
    always_comb begin
        if (!clk_probe_oen_n) begin
            sel_clk = clk_probe;
        end else begin
            sel_clk = bus_clk;
        end
    end

    always_comb begin
        if (!rst_probe_oen_n) begin
            sel_rst = rst_probe;
        end else begin
            sel_rst = bus_rst;
        end
    end

endmodule

// File: rtl/probe_load_mask.sv
module probe_load_mask #(
    parameter int CNT_W = 32
) (
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] load_oen_n,
    input  logic [CNT_W-1:0] count_q,
    output logic [CNT_W-1:0] load_mask,
    output logic [CNT_W-1:0] merged,
    output logic             any_load
);

    // One slice per counter bit: driven bits take the probe value.
    for (genvar i = 0; i < CNT_W; i++) begin : g_bit
        assign load_mask[i] = ~load_oen_n[i];
        assign merged[i]    = load_mask[i] ? load_val[i] : count_q[i];
    end

    assign any_load = |load_mask;

endmodule

// File: rtl/probe_count_core.sv
module probe_count_core
    import probe_cnt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             any_load,
    input  logic [CNT_W-1:0] merged,
    output logic [CNT_W-1:0] count_q
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    cnt_act_e         act;
    logic [CNT_W-1:0] count_d;

    // Action decode: reset first, then load, then step.
    always_comb begin
        if (rst) begin
            act = ACT_CLEAR;
        end else if (any_load) begin
            act = ACT_LOAD;
        end else begin
            act = ACT_STEP;
        end
    end

    // Next-value selection for the decoded action.
    always_comb begin
        unique case (act)
            ACT_CLEAR: count_d = '0;
            ACT_LOAD:  count_d = merged;
            ACT_STEP:  count_d = count_q + ONE;
            default:   count_d = '0;
        endcase
    end

    // Count register.
    always_ff @(posedge clk) begin
        count_q <= count_d;
    end

endmodule

// File: rtl/probe_counter_top.sv
module probe_counter_top #(
    parameter int CNT_W   = 32,
    parameter int PROBE_W = 128
) (
    input  logic               bus_clk,
    input  logic               bus_rst,
    input  logic [PROBE_W-1:0] probe_drv,
    input  logic [PROBE_W-1:0] probe_oen_n,
    output logic [PROBE_W-1:0] probe_obs
);

    localparam int LOAD_LO = CNT_W;
    localparam int CLK_BIT = 2 * CNT_W;
    localparam int RST_BIT = CLK_BIT + 1;

    logic             sel_clk;
    logic             sel_rst;
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] load_mask;
    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] merged;
    logic             any_load;
    logic             unused_probe_bits;

    assign load_val = probe_drv[LOAD_LO +: CNT_W];

    probe_src_select u_src (
        .bus_clk         (bus_clk),
        .bus_rst         (bus_rst),
        .clk_probe       (probe_drv[CLK_BIT]),
        .clk_probe_oen_n (probe_oen_n[CLK_BIT]),
        .rst_probe       (probe_drv[RST_BIT]),
        .rst_probe_oen_n (probe_oen_n[RST_BIT]),
        .sel_clk         (sel_clk),
        .sel_rst         (sel_rst)
    );

    probe_load_mask #(.CNT_W(CNT_W)) u_mask (
        .load_val   (load_val),
        .load_oen_n (probe_oen_n[LOAD_LO +: CNT_W]),
        .count_q    (count_q),
        .load_mask  (load_mask),
        .merged     (merged),
        .any_load   (any_load)
    );

    probe_count_core #(.CNT_W(CNT_W)) u_core (
        .clk      (sel_clk),
        .rst      (sel_rst),
        .any_load (any_load),
        .merged   (merged),
        .count_q  (count_q)
    );

    always_comb begin
        probe_obs            = '0;
        probe_obs[CNT_W-1:0] = count_q;
    end

    // Probe channels the counter does not consume.
    assign unused_probe_bits = ^{probe_drv[CNT_W-1:0], probe_drv[PROBE_W-1:RST_BIT+1],
                                 probe_oen_n[CNT_W-1:0], probe_oen_n[PROBE_W-1:RST_BIT+1]};

endmodule

// File: rtl/probe_counter_checker.sv
module probe_counter_checker #(
    parameter int CNT_W = 32
) (
    input logic             sel_clk,
    input logic             sel_rst,
    input logic [CNT_W-1:0] count_q,
    input logic [CNT_W-1:0] load_mask,
    input logic [CNT_W-1:0] load_val
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    // R2: the edge after a reset edge shows a cleared count.
    p_reset_clears_r2: assert property (@(posedge sel_clk) disable iff (sel_rst)
        $past(sel_rst) |-> (count_q == '0));

    // R3: an edge without reset or load adds one.
    p_step_adds_one_r3: assert property (@(posedge sel_clk) disable iff (sel_rst)
        (load_mask == '0) |=> (count_q == $past(count_q) + ONE));

    // R4: driven bits take the probe value, the other bits hold.
    p_masked_load_r4: assert property (@(posedge sel_clk) disable iff (sel_rst)
        (load_mask != '0) |=>
        (count_q == (($past(count_q) & ~$past(load_mask)) | ($past(load_val) & $past(load_mask)))));

    // R5: a held full load with a constant value keeps the count still.
    p_load_holds_r5: assert property (@(posedge sel_clk) disable iff (sel_rst)
        ((&load_mask) && (&$past(load_mask)) && $stable(load_val) && !$past(sel_rst))
        |=> $stable(count_q));

endmodule

bind probe_counter_top probe_counter_checker #(.CNT_W(CNT_W)) u_checker (
    .sel_clk   (sel_clk),
    .sel_rst   (sel_rst),
    .count_q   (count_q),
    .load_mask (load_mask),
    .load_val  (load_val)
);

// File: tb/test_probe_counter_top.sv
`timescale 1ns/1ps
module test_probe_counter_top;

    localparam int CNT_W   = 32;
    localparam int PROBE_W = 128;
    localparam int CLK_BIT = 2 * CNT_W;
    localparam int RST_BIT = CLK_BIT + 1;

    logic               bus_clk = 1'b0;
    logic               bus_rst;
    logic [PROBE_W-1:0] probe_drv;
    logic [PROBE_W-1:0] probe_oen_n;
    logic [PROBE_W-1:0] probe_obs;

    int n_checks = 0;
    int n_errs   = 0;
    logic [31:0] model;

    probe_counter_top #(.CNT_W(CNT_W), .PROBE_W(PROBE_W)) i_probe_counter_top (
        .bus_clk     (bus_clk),
        .bus_rst     (bus_rst),
        .probe_drv   (probe_drv),
        .probe_oen_n (probe_oen_n),
        .probe_obs   (probe_obs)
    );

    always #2.5 bus_clk = ~bus_clk;

    task automatic check(input string req, input logic [95:0] act, input logic [95:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic set_load(input logic [31:0] mask, input logic [31:0] val);
        probe_oen_n[CNT_W +: CNT_W] = ~mask;
        probe_drv[CNT_W +: CNT_W]   = val;
    endtask

    task automatic ptick();
        #1 probe_drv[CLK_BIT] = 1'b1;
        #0.5;
    endtask

    task automatic ptick_low();
        #0.5 probe_drv[CLK_BIT] = 1'b0;
    endtask

    initial begin
        #900000;
        n_errs++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

    initial begin
        bus_rst     = 1'b1;
        probe_drv   = '0;
        probe_oen_n = '1;
        repeat (2) @(negedge bus_clk);
        check("R2 reset value", {64'd0, probe_obs[31:0]}, 96'd0);
        check("R1 upper probe bits zero", probe_obs[127:32], 96'd0);

        // R3: free run from zero
        bus_rst = 1'b0;
        model   = 0;
        for (int k = 1; k <= 40; k++) begin
            @(negedge bus_clk);
            model = model + 1;
            check("R3 increment", {64'd0, probe_obs[31:0]}, {64'd0, model});
        end

        // R2: reset overrides a full load
        bus_rst = 1'b1;
        set_load(32'hFFFF_FFFF, 32'h1234_5678);
        @(negedge bus_clk);
        check("R2 reset beats load", {64'd0, probe_obs[31:0]}, 96'd0);

        // R4/R5: full load holds while enabled
        bus_rst = 1'b0;
        for (int k = 0; k < 5; k++) begin
            @(negedge bus_clk);
            check("R5 load held", {64'd0, probe_obs[31:0]}, {64'd0, 32'h1234_5678});
        end
        set_load(32'h0, 32'h0);
        model = 32'h1234_5678;
        for (int k = 0; k < 4; k++) begin
            @(negedge bus_clk);
            model = model + 1;
            check("R5 resume after release", {64'd0, probe_obs[31:0]}, {64'd0, model});
        end

        // R4: partial mask sweep
        for (int i = 0; i < 16; i++) begin
            logic [31:0] m;
            logic [31:0] v;
            m = 32'h0000_000F << (2 * i);
            v = 32'h1111_1111 * (i + 1);
            set_load(m, v);
            @(negedge bus_clk);
            model = (model & ~m) | (v & m);
            check("R4 partial load", {64'd0, probe_obs[31:0]}, {64'd0, model});
            set_load(32'h0, 32'h0);
            @(negedge bus_clk);
            model = model + 1;
            check("R4 step after partial load", {64'd0, probe_obs[31:0]}, {64'd0, model});
        end

        // R3: wrap
        set_load(32'hFFFF_FFFF, 32'hFFFF_FFFF);
        @(negedge bus_clk);
        set_load(32'h0, 32'h0);
        @(negedge bus_clk);
        check("R3 wrap to zero", {64'd0, probe_obs[31:0]}, 96'd0);

        // R8: load zero then run past 500
        set_load(32'hFFFF_FFFF, 32'h0);
        @(negedge bus_clk);
        set_load(32'h0, 32'h0);
        repeat (501) @(negedge bus_clk);
        check("R8 count after 501 edges", {64'd0, probe_obs[31:0]}, 96'd501);
        check("R8 exceeds 500", {95'd0, probe_obs[31:0] > 32'd500}, 96'd1);
        model = 501;

        // R7: probe reset selected, bus reset ignored
        probe_oen_n[RST_BIT] = 1'b0;
        probe_drv[RST_BIT]   = 1'b0;
        bus_rst              = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge bus_clk);
            model = model + 1;
            check("R7 bus reset ignored", {64'd0, probe_obs[31:0]}, {64'd0, model});
        end
        probe_drv[RST_BIT] = 1'b1;
        @(negedge bus_clk);
        check("R7 probe reset clears", {64'd0, probe_obs[31:0]}, 96'd0);
        probe_drv[RST_BIT] = 1'b0;
        @(negedge bus_clk);
        check("R7 probe reset released", {64'd0, probe_obs[31:0]}, 96'd1);

        // R6: probe clock, single stepping
        probe_drv[RST_BIT]   = 1'b1;
        probe_drv[CLK_BIT]   = 1'b0;
        probe_oen_n[CLK_BIT] = 1'b0;
        bus_rst              = 1'b0;
        ptick();
        check("R6 probe clock reset edge", {64'd0, probe_obs[31:0]}, 96'd0);
        ptick_low();
        probe_drv[RST_BIT] = 1'b0;
        for (int k = 1; k <= 6; k++) begin
            ptick();
            check("R6 probe clock step", {64'd0, probe_obs[31:0]}, k);
            ptick_low();
        end
        repeat (10) @(negedge bus_clk);
        check("R6 bus clock ignored", {64'd0, probe_obs[31:0]}, 96'd6);

        // R6: back to the bus clock
        probe_oen_n[CLK_BIT] = 1'b1;
        probe_oen_n[RST_BIT] = 1'b1;
        @(negedge bus_clk);
        check("R6 bus clock restored", {64'd0, probe_obs[31:0]}, 96'd7);
        check("R1 upper probe bits zero at end", probe_obs[127:32], 96'd0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

endmodule